// File: doc/BRIEF.md
# Serial Transmit Byte Queue with Low-Water Flag

This block sits between a CPU register interface and a serial transmit shifter. Software pushes bytes into a 16-slot queue. The shifter pulls them out one at a time, oldest first. A registered flag tells software that the queue has drained to a chosen low-water level, so that it can refill the queue in bursts instead of byte by byte.

A control word sets the low-water level, enables hardware flow control, and carries two one-shot flush actions. One flush empties this queue. The other is sent as a one-cycle pulse to the companion receive queue.

When flow control is on, the clear-to-send input can hold back the next byte. The request-to-send output then mirrors the receive side's hold request. When flow control is off, neither signal has any effect.

The clear-to-send input and the reset release are expected to be synchronous to `clk`.

Top module: `uart_txq`

## Requirements
- R1: After reset, `level_o` is 0, `need_data_o` is 1, and `full_o`, `rd_valid_o`, `overflow_o` and `rx_flush_o` are 0. The stored trigger code is 00 and flow control is off, so `rts_n_o` is 0.
- R2: Bytes leave the queue in the order they were written. `level_o` counts the stored bytes, and `full_o` is 1 exactly when 16 bytes are stored. A byte is removed in a cycle where `rd_valid_o` and `rd_ready_i` are both 1, and `rd_data_o` shows the oldest byte.
- R3: The trigger code is `ctrl_i[4:3]`. Code 00 selects a threshold of 8 stored bytes, 01 selects 4, 10 selects 2 and 11 selects 0. `need_data_o` becomes 1 on the same clock edge on which `level_o` reaches a value at or below the threshold.
- R4: `need_data_o` is sticky. A pulse on `need_clr_i` clears it only while the count is above the threshold. A clear while the count is at or below the threshold leaves it at 1.
- R5: A control write (`ctrl_wr_i` high) with `ctrl_i[1]`=1 empties the queue on that edge. The same write with `ctrl_i[1]`=0 leaves the stored bytes untouched.
- R6: A control write with `ctrl_i[0]`=1 makes `rx_flush_o` 1 for exactly the following cycle. A control write with `ctrl_i[0]`=0 leaves `rx_flush_o` at 0, and this queue's contents are not touched.
- R7: With flow control off (`ctrl_i[2]`=0 on the last control write), `cts_n_i` has no effect on `rd_valid_o`, and `rts_n_o` stays at 0 whatever `rx_hold_i` does.
- R8: With flow control on, `cts_n_i`=1 forces `rd_valid_o` to 0, so no byte leaves the queue. `rts_n_o` equals `rx_hold_i`.
- R9: A write while the queue is full is dropped. `overflow_o` is 1 for the following cycle, and both the level and the queued data stay unchanged.
- R10: A transmit flush in the same cycle as a write and a read wins. The queue is empty afterwards, and no overflow is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | CPU write strobe |
| wr_data_i | input | 8 | Byte to queue |
| full_o | output | 1 | Queue holds 16 bytes |
| rd_ready_i | input | 1 | Shifter takes the offered byte |
| rd_valid_o | output | 1 | A byte is offered to the shifter |
| rd_data_o | output | 8 | Oldest queued byte |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_i | input | 5 | [4:3] trigger code, [2] flow-control enable, [1] transmit flush, [0] receive flush |
| need_clr_i | input | 1 | Clear request for the needs-data flag |
| need_data_o | output | 1 | Sticky low-water flag |
| level_o | output | 5 | Number of stored bytes |
| overflow_o | output | 1 | One-cycle pulse after a dropped write |
| cts_n_i | input | 1 | Clear-to-send, active low |
| rx_hold_i | input | 1 | Receive side asks the remote end to pause |
| rts_n_o | output | 1 | Request-to-send, active low |
| rx_flush_o | output | 1 | One-cycle flush pulse to the receive queue |

## Verification
The bench walks the level down to each of the four thresholds. It looks for the flag being still clear one byte above the threshold and set exactly at it. A comparison off by one, or a flag that lags the count, shows up as a wrong flag value at that level.

It tries to clear the flag while the level is at the threshold, which catches a flag that is not sticky. It writes into a full queue and then drains it, which catches a queue that corrupts data or loses the overflow pulse. It fires a flush, a write and a read in one cycle, which catches a queue that ends non-empty or reports a false overflow.

It toggles clear-to-send and the receive hold with flow control both off and on. A design that ignores the enable either stalls the shifter or drives request-to-send when it should not.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

  localparam int unsigned CTRL_W     = 5;
  localparam int unsigned CB_RXFLUSH = 0;
  localparam int unsigned CB_TXFLUSH = 1;
  localparam int unsigned CB_FLOWEN  = 2;
  localparam int unsigned CB_TRIG_LO = 3;

  typedef enum logic [1:0] {
    TRIG_HALF  = 2'b00,
    TRIG_QUART = 2'b01,
    TRIG_EIGHT = 2'b10,
    TRIG_DRAIN = 2'b11
  } trig_code_e;

  // Threshold on stored bytes for a trigger code, scaled from the depth.
  function automatic int unsigned trig_level(trig_code_e code, int unsigned depth);
    if (code == TRIG_DRAIN) return 0;
    return depth >> (int'(code) + 1);
  endfunction

endpackage

// File: rtl/uart_txq_store.sv
module uart_txq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_req_i,
  input  logic          flush_i,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] cnt_q_o,
  output logic [CW-1:0] cnt_d_o,
  output logic [DW-1:0] head_o,
  output logic          ovf_o
);

  logic [DW-1:0] slot_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          push, pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  always_comb begin
    push   = push_req_i && !full_o && !flush_i;
    pop    = pop_req_i && !empty_o && !flush_i;
    ovf_d  = push_req_i && full_o && !flush_i;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush_i) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = wptr_q + AW'(1);
      if (pop)  rptr_d = rptr_q + AW'(1);
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  // Data storage: no reset, written only under the push enable.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && (wptr_q == AW'(i))) slot_q[i] <= push_data_i;
    end
  end

  assign head_o  = slot_q[rptr_q];
  assign cnt_q_o = cnt_q;
  assign cnt_d_o = cnt_d;
  assign ovf_o   = ovf_q;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (empty_o && !ovf_o)); // R10

  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_req_i && !pop_req_i && !flush_i) |=> (cnt_q_o == $past(cnt_q_o))); // R9

endmodule

// File: rtl/uart_txq_cfg.sv
module uart_txq_cfg
  import uart_txq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] word_i,
  output trig_code_e        code_o,
  output logic              flow_en_o,
  output logic              tx_flush_o,
  output logic              rx_flush_o
);

  trig_code_e code_q, code_d;
  logic       flow_q, flow_d;
  logic       rxf_q, rxf_d;

  always_comb begin
    code_d = code_q;
    flow_d = flow_q;
    rxf_d  = 1'b0;
    if (wr_i) begin
      code_d = trig_code_e'(word_i[CB_TRIG_LO +: 2]);
      flow_d = word_i[CB_FLOWEN];
      rxf_d  = word_i[CB_RXFLUSH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= TRIG_HALF;
      flow_q <= 1'b0;
      rxf_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      flow_q <= flow_d;
      rxf_q  <= rxf_d;
    end
  end

  assign code_o     = code_q;
  assign flow_en_o  = flow_q;
  assign tx_flush_o = wr_i && word_i[CB_TXFLUSH];
  assign rx_flush_o = rxf_q;

  AST_RXFLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush_o && !wr_i) |=> !rx_flush_o); // R6

endmodule

// File: rtl/uart_txq_trig.sv
module uart_txq_trig
  import uart_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  trig_code_e    code_i,
  input  logic [CW-1:0] cnt_q_i,
  input  logic [CW-1:0] cnt_d_i,
  input  logic          clr_i,
  output logic          flag_o
);

  logic [CW-1:0] thr;
  logic          flag_q, flag_d;

  assign thr = CW'(trig_level(code_i, DEPTH));

  // Set dominates clear, so a clear at or below the threshold has no effect.
  always_comb begin
    flag_d = flag_q;
    if (clr_i)           flag_d = 1'b0;
    if (cnt_d_i <= thr)  flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b1;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_FLAG_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(code_i) && (cnt_q_i <= thr)) |-> flag_o); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o); // R4

endmodule

// File: rtl/uart_txq_flow.sv
module uart_txq_flow (
  input  logic flow_en_i,
  input  logic empty_i,
  input  logic cts_n_i,
  input  logic rx_hold_i,
  output logic offer_o,
  output logic rts_n_o
);

  logic cts_block;

  assign cts_block = flow_en_i && cts_n_i;
  assign offer_o   = !empty_i && !cts_block;
  assign rts_n_o   = flow_en_i ? rx_hold_i : 1'b0;

endmodule

// File: rtl/uart_txq.sv
module uart_txq
  import uart_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic              full_o,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [DW-1:0]     rd_data_o,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              need_clr_i,
  output logic              need_data_o,
  output logic [CW-1:0]     level_o,
  output logic              overflow_o,
  input  logic              cts_n_i,
  input  logic              rx_hold_i,
  output logic              rts_n_o,
  output logic              rx_flush_o
);

  trig_code_e    code;
  logic          flow_en, tx_flush, empty;
  logic [CW-1:0] cnt_q, cnt_d;

  uart_txq_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (ctrl_wr_i),
    .word_i     (ctrl_i),
    .code_o     (code),
    .flow_en_o  (flow_en),
    .tx_flush_o (tx_flush),
    .rx_flush_o (rx_flush_o)
  );

  uart_txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_req_i  (wr_valid_i),
    .push_data_i (wr_data_i),
    .pop_req_i   (rd_ready_i && rd_valid_o),
    .flush_i     (tx_flush),
    .full_o      (full_o),
    .empty_o     (empty),
    .cnt_q_o     (cnt_q),
    .cnt_d_o     (cnt_d),
    .head_o      (rd_data_o),
    .ovf_o       (overflow_o)
  );

  uart_txq_trig #(.DEPTH(DEPTH)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_i  (code),
    .cnt_q_i (cnt_q),
    .cnt_d_i (cnt_d),
    .clr_i   (need_clr_i),
    .flag_o  (need_data_o)
  );

  uart_txq_flow u_flow (
    .flow_en_i (flow_en),
    .empty_i   (empty),
    .cts_n_i   (cts_n_i),
    .rx_hold_i (rx_hold_i),
    .offer_o   (rd_valid_o),
    .rts_n_o   (rts_n_o)
  );

  assign level_o = cnt_q;

  AST_CTS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && cts_n_i && !tx_flush) |=> (level_o >= $past(level_o))); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_o || tx_flush) |=> !overflow_o); // R9

endmodule

// File: tb/uart_txq_tb.sv
`timescale 1ns/100ps
module uart_txq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_valid_i, rd_ready_i, ctrl_wr_i, need_clr_i, cts_n_i, rx_hold_i;
  logic [7:0] wr_data_i;
  logic [4:0] ctrl_i;
  logic       full_o, rd_valid_o, need_data_o, overflow_o, rts_n_o, rx_flush_o;
  logic [7:0] rd_data_o;
  logic [4:0] level_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  uart_txq u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .full_o(full_o),
    .rd_ready_i(rd_ready_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .ctrl_wr_i(ctrl_wr_i), .ctrl_i(ctrl_i), .need_clr_i(need_clr_i),
    .need_data_o(need_data_o), .level_o(level_o), .overflow_o(overflow_o),
    .cts_n_i(cts_n_i), .rx_hold_i(rx_hold_i), .rts_n_o(rts_n_o),
    .rx_flush_o(rx_flush_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Thresholds per trigger code, taken from R3.
  function automatic int exp_thr(input int code);
    case (code)
      0: return 8;
      1: return 4;
      2: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic push(input logic [7:0] d);
    @(negedge clk); wr_valid_i = 1'b1; wr_data_i = d;
    @(negedge clk); wr_valid_i = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rd_ready_i = 1'b1;
    @(negedge clk); rd_ready_i = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [1:0] code, input logic fl, input logic txf, input logic rxf);
    @(negedge clk); ctrl_wr_i = 1'b1; ctrl_i = {code, fl, txf, rxf};
    @(negedge clk); ctrl_wr_i = 1'b0;
  endtask

  task automatic clr_flag();
    @(negedge clk); need_clr_i = 1'b1;
    @(negedge clk); need_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 level", level_o, 0);
    chk("R1 need_data", need_data_o, 1);
    chk("R1 full", full_o, 0);
    chk("R1 rd_valid", rd_valid_o, 0);
    chk("R1 overflow", overflow_o, 0);
    chk("R1 rx_flush", rx_flush_o, 0);
    chk("R1 rts_n", rts_n_o, 0);
  endtask

  task automatic t_order_and_half();
    for (int i = 0; i < 16; i++) push(8'(i * 7 + 3));
    chk("R2 level full", level_o, 16);
    chk("R2 full", full_o, 1);
    chk("R4 flag sticky from reset", need_data_o, 1);
    clr_flag();
    chk("R4 clear above threshold", need_data_o, 0);
    push(8'hEE);
    chk("R9 overflow pulse", overflow_o, 1);
    chk("R9 level kept", level_o, 16);
    @(negedge clk);
    chk("R9 overflow single", overflow_o, 0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R2 valid", rd_valid_o, 1);
      chk("R2 order", rd_data_o, 8'(i * 7 + 3));
      pop();
      if (i == 6) chk("R3 code00 above (9)", need_data_o, 0);
      if (i == 7) chk("R3 code00 at 8", need_data_o, 1);
    end
    chk("R2 empty level", level_o, 0);
    chk("R2 empty valid", rd_valid_o, 0);
  endtask

  task automatic t_codes();
    for (int c = 1; c < 4; c++) begin
      int th;
      th = exp_thr(c);
      wr_ctrl(2'(c), 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < 16; i++) push(8'(i));
      clr_flag();
      chk("R4 clear at full", need_data_o, 0);
      while (int'(level_o) > th + 1) pop();
      chk("R3 flag clear above threshold", need_data_o, 0);
      pop();
      chk("R3 level at threshold", level_o, 5'(th));
      chk("R3 flag set at threshold", need_data_o, 1);
      clr_flag();
      chk("R4 clear ignored at threshold", need_data_o, 1);
    end
  endtask

  task automatic t_flush();
    wr_ctrl(2'd0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) push(8'(i + 40));
    chk("R5 pre-flush level", level_o, 5);
    wr_ctrl(2'd0, 1'b0, 1'b1, 1'b0);
    chk("R5 flushed level", level_o, 0);
    chk("R5 flushed valid", rd_valid_o, 0);
    chk("R6 no rx pulse on tx flush", rx_flush_o, 0);
    for (int i = 0; i < 3; i++) push(8'(i + 60));
    wr_ctrl(2'd0, 1'b0, 1'b0, 1'b0);
    chk("R5 flush bit 0 keeps level", level_o, 3);
    wr_ctrl(2'd0, 1'b0, 1'b0, 1'b1);
    chk("R6 rx flush pulse", rx_flush_o, 1);
    chk("R6 tx untouched", level_o, 3);
    @(negedge clk);
    chk("R6 rx flush one cycle", rx_flush_o, 0);
    chk("R5 head kept", rd_data_o, 8'd60);
  endtask

  task automatic t_priority();
    @(negedge clk);
    wr_valid_i = 1'b1; wr_data_i = 8'h55; rd_ready_i = 1'b1;
    ctrl_wr_i  = 1'b1; ctrl_i = 5'b00010;
    @(negedge clk);
    wr_valid_i = 1'b0; rd_ready_i = 1'b0; ctrl_wr_i = 1'b0;
    chk("R10 level after flush race", level_o, 0);
    chk("R10 no overflow", overflow_o, 0);
    chk("R10 valid low", rd_valid_o, 0);
  endtask

  task automatic t_modem();
    push(8'hA1);
    cts_n_i = 1'b1; rx_hold_i = 1'b1;
    #1;
    chk("R7 cts ignored", rd_valid_o, 1);
    chk("R7 rts not driven", rts_n_o, 0);
    wr_ctrl(2'd0, 1'b1, 1'b0, 1'b0);
    chk("R8 cts blocks", rd_valid_o, 0);
    chk("R8 rts follows hold", rts_n_o, 1);
    rx_hold_i = 1'b0;
    #1;
    chk("R8 rts follows release", rts_n_o, 0);
    pop();
    chk("R8 no byte taken", level_o, 1);
    cts_n_i = 1'b0;
    #1;
    chk("R8 cts low offers", rd_valid_o, 1);
    chk("R8 data", rd_data_o, 8'hA1);
    pop();
    chk("R8 byte taken", level_o, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_valid_i = 1'b0; wr_data_i = '0; rd_ready_i = 1'b0;
    ctrl_wr_i = 1'b0; ctrl_i = '0; need_clr_i = 1'b0;
    cts_n_i = 1'b0; rx_hold_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order_and_half();
    t_codes();
    t_flush();
    t_priority();
    t_modem();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule